// File: doc/BRIEF.md
# AES Key Schedule Generator

This unit expands a 128-, 192- or 256-bit cipher key into the complete AES round-key schedule. A start pulse with a valid size code copies the key into an internal word store in one cycle. A serial generator then derives one 32-bit schedule word per clock. It has a single shared four-byte substitution stage, a byte rotation and a round-constant register that is advanced in GF(2^8).

When the last word is in the store, a ready flag rises. A cipher datapath then reads complete 128-bit round keys by round index through a combinational read port. The port has a valid flag that marks each read as usable or not.

Top module: `aes_key_expander`

## Requirements
- R1: After reset, `ready`, `busy` and `rd_valid` are 0 and `rd_key` is all zeros.
- R2: `key_size` code 0 selects a 128-bit key (Nk=4, 44 words, Nr=10), code 1 a 192-bit key (Nk=6, 52 words, Nr=12) and code 2 a 256-bit key (Nk=8, 60 words, Nr=14). A start with code 3 is ignored: `busy` stays 0 and the stored schedule and `ready` do not change.
- R3: Schedule words 0 to Nk-1 equal the key. Word 0 is `key_in[255:224]` and word k is `key_in[255-32k -: 32]`. A 128-bit key uses `key_in[255:128]` and a 192-bit key uses `key_in[255:64]`.
- R4: For a word i with i mod Nk = 0, w[i] = w[i-Nk] XOR SubWord(RotWord(w[i-1])) XOR {rc, 24'h0}. RotWord moves the top byte to the bottom. The constant rc takes the values 01, 02, 04, 08, 10, 20, 40, 80, 1b, 36 on successive uses.
- R5: With Nk=8 and i mod 8 = 4, w[i] = w[i-8] XOR SubWord(w[i-1]). No rotation and no constant are applied.
- R6: Every other word is w[i-Nk] XOR w[i-1].
- R7: One word is produced per clock. `ready` rises (total words - Nk + 1) clocks after the edge that accepts start, which is one clock after the last word is written. `busy` is high from the accepting edge until `ready` rises.
- R8: `rd_key` returns words 4r..4r+3 for `rd_round` = r, with word 4r in bits 127:96. `rd_valid` is 1 only when `ready` is 1 and r <= Nr. When `rd_valid` is 0, `rd_key` is zero.
- R9: A start while `busy` is ignored. The schedule being built is unaffected.
- R10: A valid start while `ready` is 1 restarts expansion, and `ready` is 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start expansion (one-cycle pulse) |
| key_size | input | 2 | Key size code (0:128, 1:192, 2:256) |
| key_in | input | 256 | Cipher key, first word in the top bits |
| rd_round | input | 4 | Round index to read |
| rd_key | output | 128 | Round key for `rd_round` |
| rd_valid | output | 1 | Read result is usable |
| ready | output | 1 | Schedule complete |
| busy | output | 1 | Expansion in progress |

## Verification
The bench builds the block with its default parameters: 32-bit words and a maximum Nk of 8. These give a 60-word store and a 4-bit round index, so all three key sizes can be exercised, including the Nk=8 extra substitution and the out-of-range index 15. A behavioural model compares every round key against an independent computation. It also checks the published last-round keys for each size. The bench checks the cycle of `ready` to the exact clock. During each expansion it checks `ready`, `busy` and `rd_valid` on every clock, and it injects starts while the block is busy and while it is ready.

// File: rtl/kx_pkg.sv
package kx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_GEN  = 2'd1,
      ST_FIN  = 2'd2
   } kx_state_e;

   localparam logic [1:0] KS_128 = 2'd0;
   localparam logic [1:0] KS_192 = 2'd1;
   localparam logic [1:0] KS_256 = 2'd2;

   // words in the key for a size code, 0 marks an unsupported code
   function automatic logic [3:0] ks_nk(input logic [1:0] code);
      case (code)
         KS_128:  ks_nk = 4'd4;
         KS_192:  ks_nk = 4'd6;
         KS_256:  ks_nk = 4'd8;
         default: ks_nk = 4'd0;
      endcase
   endfunction

   function automatic logic [7:0] gf_dbl(input logic [7:0] a);
      gf_dbl = {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] aa;
      acc = 8'h00;
      aa  = a;
      for (int k = 0; k < 8; k++) begin
         if (b[k]) acc = acc ^ aa;
         aa = gf_dbl(aa);
      end
      gf_mul = acc;
   endfunction

   // multiplicative inverse as a^254, zero maps to zero
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] res;
      logic [7:0] base;
      res  = 8'h01;
      base = a;
      for (int k = 0; k < 8; k++) begin
         if (k != 0) res = gf_mul(res, base);
         base = gf_mul(base, base);
      end
      gf_inv = res;
   endfunction

   function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
      rotl8 = (v << n) | (v >> (8 - n));
   endfunction

   function automatic logic [7:0] fwd_sbox(input logic [7:0] x);
      logic [7:0] q;
      q = gf_inv(x);
      fwd_sbox = q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4) ^ 8'h63;
   endfunction

endpackage

// File: rtl/kx_subword.sv
module kx_subword #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);
   localparam int NBYTES = WORD_W / 8;

   if (WORD_W % 8 != 0) begin : g_bad_w
      $error("kx_subword: WORD_W must be a multiple of 8");
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign dout[b*8 +: 8] = kx_pkg::fwd_sbox(din[b*8 +: 8]);
   end
endmodule

// File: rtl/kx_rcon.sv
module kx_rcon (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       step,
   output logic [7:0] rcon
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rcon <= 8'h01;
      else if (clear) rcon <= 8'h01;
      else if (step)  rcon <= kx_pkg::gf_dbl(rcon);
   end

   AST_RCON_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rcon != 8'h00); // R4
   AST_RCON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> rcon == 8'h01); // R4
endmodule

// File: rtl/kx_word_store.sv
module kx_word_store #(
   parameter int WORD_W = 32,
   parameter int MAX_NK = 8,
   parameter int DEPTH  = 4 * (MAX_NK + 7),
   parameter int AW     = $clog2(DEPTH),
   parameter int RW     = $clog2(MAX_NK + 7)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_en,
   input  logic [3:0]               load_nk,
   input  logic [MAX_NK*WORD_W-1:0] key_words,
   input  logic                     wr_en,
   input  logic [AW-1:0]            wr_addr,
   input  logic [WORD_W-1:0]        wr_data,
   input  logic [AW-1:0]            back_addr,
   output logic [WORD_W-1:0]        back_word,
   input  logic [RW-1:0]            rnd_idx,
   output logic [4*WORD_W-1:0]      rnd_words
);
   localparam int RA = RW + 2;

   if (DEPTH < 4 * (MAX_NK + 7)) begin : g_bad_depth
      $error("kx_word_store: DEPTH too small for the largest key");
   end

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      end else if (load_en) begin
         for (int k = 0; k < MAX_NK; k++)
            if (k < int'(load_nk))
               mem[k] <= key_words[(MAX_NK-1-k)*WORD_W +: WORD_W];
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign back_word = mem[back_addr];

   for (genvar j = 0; j < 4; j++) begin : g_rd
      logic [RA-1:0] addr;
      assign addr = {rnd_idx, 2'b00} + RA'(j);
      assign rnd_words[(3-j)*WORD_W +: WORD_W] =
         (int'(addr) < DEPTH) ? mem[AW'(addr)] : '0;
   end

   AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> int'(wr_addr) < DEPTH); // R7
   AST_NO_LOAD_WRITE_MIX: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_en && wr_en)); // R3
endmodule

// File: rtl/aes_key_expander.sv
module aes_key_expander #(
   parameter int WORD_W = 32,
   parameter int MAX_NK = 8,
   localparam int DEPTH = 4 * (MAX_NK + 7),
   localparam int AW    = $clog2(DEPTH),
   localparam int RW    = $clog2(MAX_NK + 7)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [1:0]               key_size,
   input  logic [MAX_NK*WORD_W-1:0] key_in,
   input  logic [RW-1:0]            rd_round,
   output logic [4*WORD_W-1:0]      rd_key,
   output logic                     rd_valid,
   output logic                     ready,
   output logic                     busy
);
   import kx_pkg::*;

   if (WORD_W != 32) begin : g_bad_word
      $error("aes_key_expander: WORD_W must be 32");
   end
   if (MAX_NK != 8) begin : g_bad_nk
      $error("aes_key_expander: MAX_NK must be 8 to cover every key size");
   end

   kx_state_e         state_q;
   logic [3:0]        nk_q;
   logic [AW-1:0]     last_q;
   logic [AW-1:0]     idx_q;
   logic [2:0]        kcnt_q;
   logic [WORD_W-1:0] prev_q;
   logic              ready_q;

   logic [3:0]        nk_in;
   logic              accept;
   logic [AW-1:0]     back_addr;
   logic [WORD_W-1:0] back_word;
   logic [WORD_W-1:0] rot_word;
   logic [WORD_W-1:0] sub_in;
   logic [WORD_W-1:0] sub_out;
   logic [WORD_W-1:0] mix_word;
   logic [WORD_W-1:0] new_word;
   logic [7:0]        rcon;
   logic              gen;
   logic              at_rcon;
   logic              at_mid;
   logic [4*WORD_W-1:0] rnd_words;
   logic [RW-1:0]     nr;

   assign nk_in  = ks_nk(key_size);
   assign accept = start && (state_q == ST_IDLE) && (nk_in != 4'd0);
   assign gen    = (state_q == ST_GEN);

   assign back_addr = idx_q - AW'(nk_q);
   assign rot_word  = {prev_q[WORD_W-9:0], prev_q[WORD_W-1 -: 8]};
   assign at_rcon   = (kcnt_q == 3'd0);
   assign at_mid    = (nk_q == 4'd8) && (kcnt_q == 3'd4);
   assign sub_in    = at_rcon ? rot_word : prev_q;

   kx_subword #(.WORD_W(WORD_W)) u_sub (
      .din  (sub_in),
      .dout (sub_out)
   );

   kx_rcon u_rcon (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .step  (gen && at_rcon),
      .rcon  (rcon)
   );

   always_comb begin
      if (at_rcon)     mix_word = sub_out ^ {rcon, {(WORD_W-8){1'b0}}};
      else if (at_mid) mix_word = sub_out;
      else             mix_word = prev_q;
   end

   assign new_word = back_word ^ mix_word;

   kx_word_store #(.WORD_W(WORD_W), .MAX_NK(MAX_NK), .DEPTH(DEPTH), .AW(AW), .RW(RW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (accept),
      .load_nk   (nk_in),
      .key_words (key_in),
      .wr_en     (gen),
      .wr_addr   (idx_q),
      .wr_data   (new_word),
      .back_addr (back_addr),
      .back_word (back_word),
      .rnd_idx   (rd_round),
      .rnd_words (rnd_words)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         nk_q    <= 4'd4;
         last_q  <= '0;
         idx_q   <= '0;
         kcnt_q  <= '0;
         prev_q  <= '0;
         ready_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               state_q <= ST_GEN;
               nk_q    <= nk_in;
               last_q  <= AW'(4 * (int'(nk_in) + 7) - 1);
               idx_q   <= AW'(nk_in);
               kcnt_q  <= '0;
               prev_q  <= key_in[(MAX_NK - int'(nk_in)) * WORD_W +: WORD_W];
               ready_q <= 1'b0;
            end
            ST_GEN: begin
               prev_q <= new_word;
               idx_q  <= idx_q + 1'b1;
               kcnt_q <= (kcnt_q == 3'(nk_q - 4'd1)) ? 3'd0 : kcnt_q + 3'd1;
               if (idx_q == last_q) state_q <= ST_FIN;
            end
            ST_FIN: begin
               ready_q <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign nr       = RW'(nk_q + 4'd6);
   assign ready    = ready_q;
   assign busy     = (state_q != ST_IDLE);
   assign rd_valid = ready_q && (rd_round <= nr);
   assign rd_key   = rd_valid ? rnd_words : '0;

   AST_VALID_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ready); // R8
   AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !busy); // R7
   AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(state_q == ST_FIN)); // R7
   AST_BAD_SIZE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && key_size == 2'd3) |=> !busy); // R2
   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (gen && start) |=> $stable(nk_q)); // R9
   AST_RESTART_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !ready); // R10
endmodule

// File: tb/aes_key_expander_test.sv
module aes_key_expander_test;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         start;
   logic [1:0]   key_size;
   logic [255:0] key_in;
   logic [3:0]   rd_round;
   logic [127:0] rd_key;
   logic         rd_valid;
   logic         ready;
   logic         busy;

   int errors = 0;
   int checks = 0;
   logic [7:0]  sb [256];
   logic [31:0] mw [60];

   localparam logic [255:0] K128 = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
   localparam logic [255:0] K192 = {192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0};
   localparam logic [255:0] K256 = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;

   always #2 clk = ~clk;

   aes_key_expander uut (
      .clk(clk), .rst_n(rst_n), .start(start), .key_size(key_size), .key_in(key_in),
      .rd_round(rd_round), .rd_key(rd_key), .rd_valid(rd_valid), .ready(ready), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] xt(input logic [7:0] a);
      return (a << 1) ^ ((a & 8'h80) != 0 ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [31:0] sw(input logic [31:0] v);
      return {sb[v[31:24]], sb[v[23:16]], sb[v[15:8]], sb[v[7:0]]};
   endfunction

   // S-box table from walking generator 3 and its inverse generator together
   task automatic build_sbox();
      int p = 1;
      int q = 1;
      do begin
         int x;
         p = (p ^ (p << 1) ^ (((p & 8'h80) != 0) ? 8'h1b : 0)) & 8'hff;
         q = (q ^ (q << 1)) & 8'hff;
         q = (q ^ (q << 2)) & 8'hff;
         q = (q ^ (q << 4)) & 8'hff;
         if ((q & 8'h80) != 0) q = q ^ 8'h09;
         x = q ^ ((q << 1) | (q >> 7)) ^ ((q << 2) | (q >> 6)) ^ ((q << 3) | (q >> 5)) ^ ((q << 4) | (q >> 4));
         sb[p] = 8'((x ^ 8'h63) & 8'hff);
      end while (p != 1);
      sb[0] = 8'h63;
   endtask

   task automatic build_model(input logic [255:0] key, input int nk);
      logic [7:0] rc = 8'h01;
      for (int i = 0; i < nk; i++) mw[i] = key[255 - 32*i -: 32];
      for (int i = nk; i < 4*(nk+7); i++) begin
         logic [31:0] t = mw[i-1];
         if (i % nk == 0) begin
            t = sw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
            rc = xt(rc);
         end else if (nk == 8 && i % 8 == 4) begin
            t = sw(t);
         end
         mw[i] = mw[i-nk] ^ t;
      end
   endtask

   // one expansion; optional stray start while busy
   task automatic run(input logic [255:0] key, input logic [1:0] ks, input int nk, input bit poke);
      int n = 0;
      @(negedge clk);
      key_in = key; key_size = ks; start = 1'b1; rd_round = 4'd0;
      @(negedge clk);
      start = 1'b0;
      chk(ready == 1'b0, "R10 ready low after start", 128'(ready), 128'(0));
      chk(busy == 1'b1, "R7 busy after start", 128'(busy), 128'(1));
      while (!ready && n < 200) begin
         chk(!rd_valid && rd_key == '0, "R8 read before ready invalid", rd_key, 128'(0));
         if (poke && n == 5) begin
            key_in = ~key; key_size = 2'd2; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      key_in = key;
      chk(n == 4*(nk+7) - nk + 1, "R7 ready latency", 128'(n), 128'(4*(nk+7) - nk + 1));
      chk(busy == 1'b0, "R7 busy low at ready", 128'(busy), 128'(0));
   endtask

   task automatic verify(input logic [255:0] key, input int nk, input string tag);
      build_model(key, nk);
      for (int r = 0; r <= nk + 6; r++) begin
         logic [127:0] e;
         rd_round = 4'(r);
         #1;
         e = {mw[4*r], mw[4*r+1], mw[4*r+2], mw[4*r+3]};
         chk(rd_valid == 1'b1, "R8 valid in range", 128'(rd_valid), 128'(1));
         chk(rd_key == e, {tag, " R3 R4 R5 R6 round key"}, rd_key, e);
      end
      rd_round = 4'(nk + 7);
      #1;
      chk(rd_valid == 1'b0 && rd_key == '0, "R8 index past Nr", rd_key, 128'(0));
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; key_size = 2'd0; key_in = '0; rd_round = 4'd0;
      build_sbox();
      repeat (3) @(negedge clk);
      #1;
      chk(!ready && !busy && !rd_valid && rd_key == '0, "R1 reset state",
          {ready, busy, rd_valid, rd_key[124:0]}, 128'(0));
      rst_n = 1'b1;

      // 128-bit key, published last round key
      run(K128, 2'd0, 4, 1'b0);
      verify(K128, 4, "R2 size 128");
      rd_round = 4'd10; #1;
      chk(rd_key == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R4 R6 published 128", rd_key,
          128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
      rd_round = 4'd0; #1;
      chk(rd_key == K128[255:128], "R3 key copied", rd_key, K128[255:128]);

      // unsupported size code: nothing changes
      @(negedge clk);
      key_size = 2'd3; key_in = K256; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!busy && ready, "R2 code 3 ignored", {busy, ready}, 128'h1);
      @(negedge clk);
      chk(ready && rd_key == K128[255:128], "R2 code 3 keeps schedule", rd_key, K128[255:128]);

      // 192-bit key with a stray start while busy (restarts from ready)
      run(K192, 2'd1, 6, 1'b1);
      verify(K192, 6, "R9 busy start ignored, size 192");
      rd_round = 4'd12; #1;
      chk(rd_key == 128'he98ba06f448c773c8ecc720401002202, "R4 R6 published 192", rd_key,
          128'he98ba06f448c773c8ecc720401002202);

      // 256-bit key, the mid-block substitution
      run(K256, 2'd2, 8, 1'b0);
      verify(K256, 8, "R2 size 256");
      rd_round = 4'd3; #1;
      chk(rd_key[127:96] == 32'ha8b09c1a, "R5 word 12", 128'(rd_key[127:96]), 128'h a8b09c1a);
      rd_round = 4'd14; #1;
      chk(rd_key == 128'hfe4890d1e6188d0b046df344706c631e, "R4 R5 published 256", rd_key,
          128'hfe4890d1e6188d0b046df344706c631e);

      // second 128 run from ready: restart behaviour R10
      run(K128, 2'd0, 4, 1'b0);
      verify(K128, 4, "R10 restart 128");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule